// File: doc/BRIEF.md
# PWM Multi-Level LCD Drive Generator

This block drives the COM and SEG pins of a passive segment LCD so that, after the RC low-pass filtering formed by the glass and any external series resistance, each pin sits at one of the intermediate voltages of a conventional multi-level bias scheme. Every pin is a single digital line. A level of k/B of the drive voltage is produced as a pulse train that is high for k of every B step-clock enables. The bias denominator B is selectable from 2 to 5.

A sub-frame tick walks the block through the frame. In type A mode a frame has M sub-frames. In type B mode it has 2M sub-frames, and the second half repeats the first with the polarity inverted. The number of commons M, the bias and the waveform type are taken in only when a frame ends, so a frame is never mixed. A dead-period input forces every pin high, which is used for contrast control. At half bias the segment levels land on the rails, so only the commons carry a pulse train.

Top module: `lcdpwm_drive`

## Requirements
- R1: `bias_sel` 0,1,2,3 selects B = 2,3,4,5. A step counter runs 0..B-1 and advances on each `step_en`. A level k drives the pin high while the step count is below k, so one PWM period is B enables long.
- R2: In type A (`wave_b`=0) a frame has M sub-frames, and common i is addressed in sub-frame i. The polarity starts positive at each frame start and flips each time the step counter wraps from B-1 to 0.
- R3: In type B (`wave_b`=1) a frame has 2M sub-frames. Common i is addressed in sub-frames i and M+i. Sub-frames 0..M-1 are positive and sub-frames M..2M-1 are negative.
- R4: COM levels. The addressed common is at B when positive and 0 when negative. A non-addressed common below M is at 1 when positive and B-1 when negative. Commons with index M or higher stay low.
- R5: SEG levels. Pixel bit `pix[s*NCOM + c]` (1 = on) belongs to segment s and common c. With the addressed common c, an on pixel is at 0 when positive and B when negative, and an off pixel is at 2 when positive and B-2 when negative. At B=2 every segment level is therefore a rail.
- R6: While `dead` is high, every COM and SEG output is 1 one clock later.
- R7: `bias_sel`, `com_num` and `wave_b` are taken in only on a `sf_tick` in the last sub-frame of a frame. That tick also returns the step counter to 0 and the polarity to positive, and it starts sub-frame 0.
- R8: `com_num` values below 2 are treated as 2, and values above NCOM are treated as NCOM.
- R9: During reset all outputs are 0. Reset leaves B=2, M=NCOM, type A, sub-frame 0 and step 0.
- R10: Outputs are registered. Each output is a function of the state and inputs one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | PWM step enable |
| sf_tick | input | 1 | Advance to the next sub-frame |
| bias_sel | input | 2 | Bias denominator code (B = code+2) |
| com_num | input | CW | Requested number of commons |
| wave_b | input | 1 | 1 = type B frame, 0 = type A frame |
| pix | input | NCOM*NSEG | Pixel frame buffer, one bit per segment/common pair |
| dead | input | 1 | Dead period, forces all outputs high |
| com_o | output | NCOM | Common PWM lines |
| seg_o | output | NSEG | Segment PWM lines |

## Verification
Errors in the step counter or the polarity bit show up as duty patterns that are shifted or inverted. They appear on every active common within one PWM period. An error in the sub-frame counter or the addressed-common index moves the rail level to the wrong common. It also picks the wrong pixel column, and this is seen at the next sub-frame tick. Settings that are taken in mid-frame change the period length or the active common count before the frame ends, so they appear within B step enables. Because a cycle-accurate model is compared on every output every clock, any such fault is caught at its first visible cycle.

// File: rtl/lcdpwm_pkg.sv
package lcdpwm_pkg;
  localparam int LVW = 3;
  typedef logic [LVW-1:0] lvl_t;

  // Bias denominator from its 2-bit code.
  function automatic lvl_t bias_den(input logic [1:0] sel);
    return lvl_t'(sel) + lvl_t'(2);
  endfunction

  // PWM: high during the first lvl steps of the period.
  function automatic logic pwm_bit(input lvl_t ph, input lvl_t lvl);
    return ph < lvl;
  endfunction

  function automatic lvl_t com_level(input logic active, input logic addressed,
                                     input logic neg, input lvl_t den);
    if (!active)  return '0;
    if (addressed) return neg ? lvl_t'(0) : den;
    return neg ? den - lvl_t'(1) : lvl_t'(1);
  endfunction

  function automatic lvl_t seg_level(input logic on, input logic neg, input lvl_t den);
    if (on) return neg ? den : lvl_t'(0);
    return neg ? den - lvl_t'(2) : lvl_t'(2);
  endfunction
endpackage

// File: rtl/lcdpwm_seq.sv
module lcdpwm_seq import lcdpwm_pkg::*; #(
  parameter int NCOM = 8,
  parameter int CW   = $clog2(NCOM + 1),
  parameter int SFW  = $clog2(2 * NCOM)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sf_tick,
  input  logic [1:0]     bias_sel,
  input  logic [CW-1:0]  com_num,
  input  logic           wave_b,
  output lvl_t           den,
  output logic [SFW-1:0] cur_m,
  output logic           cur_wb,
  output logic [SFW-1:0] addr_idx,
  output logic           second_half,
  output logic           frame_wrap
);
  logic [1:0]     cur_sel;
  logic [SFW-1:0] sf;
  logic [SFW:0]   nsf;
  logic [SFW-1:0] m_clamped;

  // R8: clamp the requested common count
  always_comb begin
    if (int'(com_num) < 2)         m_clamped = SFW'(2);
    else if (int'(com_num) > NCOM) m_clamped = SFW'(NCOM);
    else                           m_clamped = SFW'(com_num);
  end

  assign den         = bias_den(cur_sel);
  assign nsf         = cur_wb ? {cur_m, 1'b0} : {1'b0, cur_m};
  assign frame_wrap  = sf_tick && ({1'b0, sf} == nsf - 1'b1);
  assign second_half = cur_wb && (sf >= cur_m);
  assign addr_idx    = second_half ? sf - cur_m : sf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sf      <= '0;
      cur_sel <= 2'd0;
      cur_m   <= SFW'(NCOM);
      cur_wb  <= 1'b0;
    end else if (frame_wrap) begin
      sf      <= '0;
      cur_sel <= bias_sel;
      cur_m   <= m_clamped;
      cur_wb  <= wave_b;
    end else if (sf_tick) begin
      sf <= sf + 1'b1;
    end
  end

  a_r7_settings_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_wrap) |-> ($stable(cur_sel) && $stable(cur_m) && $stable(cur_wb)));
  a_r2_subframe_range: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, sf} < nsf);
  a_r8_m_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cur_m) >= 2) && (int'(cur_m) <= NCOM));
endmodule

// File: rtl/lcdpwm_phase.sv
module lcdpwm_phase import lcdpwm_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic frame_wrap,
  input  lvl_t den,
  input  logic wave_b,
  output lvl_t ph,
  output logic half
);
  logic period_end;
  assign period_end = step_en && (ph == den - lvl_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || frame_wrap) begin
      ph   <= '0;
      half <= 1'b0;
    end else if (period_end) begin
      ph   <= '0;
      half <= wave_b ? half : ~half;   // R2 polarity flip in type A
    end else if (step_en) begin
      ph <= ph + lvl_t'(1);
    end
  end

  a_r1_phase_range: assert property (@(posedge clk) disable iff (!rst_n) ph < den);
  a_r7_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_wrap) |-> (ph == '0 && !half));
endmodule

// File: rtl/lcdpwm_lanes.sv
module lcdpwm_lanes import lcdpwm_pkg::*; #(
  parameter int NCOM = 8,
  parameter int NSEG = 8,
  parameter int SFW  = $clog2(2 * NCOM)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  lvl_t                 ph,
  input  lvl_t                 den,
  input  logic                 neg,
  input  logic [SFW-1:0]       addr_idx,
  input  logic [SFW-1:0]       cur_m,
  input  logic [NCOM*NSEG-1:0] pix,
  input  logic                 dead,
  output logic [NCOM-1:0]      com_o,
  output logic [NSEG-1:0]      seg_o
);
  localparam int AW = $clog2(NCOM);
  logic [AW-1:0] col;
  assign col = addr_idx[AW-1:0];

  for (genvar i = 0; i < NCOM; i++) begin : g_com
    logic lvl_bit;
    assign lvl_bit = pwm_bit(ph, com_level(SFW'(i) < cur_m, addr_idx == SFW'(i), neg, den));
    always_ff @(posedge clk) begin
      if (!rst_n) com_o[i] <= 1'b0;
      else        com_o[i] <= dead | lvl_bit;
    end
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    logic [NCOM-1:0] row;
    logic            lvl_bit;
    assign row     = pix[j*NCOM +: NCOM];
    assign lvl_bit = pwm_bit(ph, seg_level(row[col], neg, den));
    always_ff @(posedge clk) begin
      if (!rst_n) seg_o[j] <= 1'b0;
      else        seg_o[j] <= dead | lvl_bit;
    end
  end

  a_r6_dead_all_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dead) |-> (&com_o && &seg_o));
endmodule

// File: rtl/lcdpwm_drive.sv
module lcdpwm_drive import lcdpwm_pkg::*; #(
  parameter int NCOM = 8,
  parameter int NSEG = 8,
  parameter int CW   = $clog2(NCOM + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 step_en,
  input  logic                 sf_tick,
  input  logic [1:0]           bias_sel,
  input  logic [CW-1:0]        com_num,
  input  logic                 wave_b,
  input  logic [NCOM*NSEG-1:0] pix,
  input  logic                 dead,
  output logic [NCOM-1:0]      com_o,
  output logic [NSEG-1:0]      seg_o
);
  localparam int SFW = $clog2(2 * NCOM);

  lvl_t           den, ph;
  logic [SFW-1:0] cur_m, addr_idx;
  logic           cur_wb, second_half, frame_wrap, half, neg;

  lcdpwm_seq #(.NCOM(NCOM), .CW(CW), .SFW(SFW)) u_seq (
    .clk(clk), .rst_n(rst_n), .sf_tick(sf_tick), .bias_sel(bias_sel),
    .com_num(com_num), .wave_b(wave_b), .den(den), .cur_m(cur_m),
    .cur_wb(cur_wb), .addr_idx(addr_idx), .second_half(second_half),
    .frame_wrap(frame_wrap));

  lcdpwm_phase u_phase (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .frame_wrap(frame_wrap),
    .den(den), .wave_b(cur_wb), .ph(ph), .half(half));

  // R2/R3 polarity source: per-period toggle (A) or frame half (B)
  assign neg = cur_wb ? second_half : half;

  lcdpwm_lanes #(.NCOM(NCOM), .NSEG(NSEG), .SFW(SFW)) u_lanes (
    .clk(clk), .rst_n(rst_n), .ph(ph), .den(den), .neg(neg),
    .addr_idx(addr_idx), .cur_m(cur_m), .pix(pix), .dead(dead),
    .com_o(com_o), .seg_o(seg_o));

  a_r3_b_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    addr_idx < cur_m);
endmodule

// File: tb/lcdpwm_drive_test.sv
module lcdpwm_drive_test;
  localparam int NCOM = 8;
  localparam int NSEG = 8;
  localparam int CW   = $clog2(NCOM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_en = 1'b0, sf_tick = 1'b0, wave_b = 1'b0, dead = 1'b0;
  logic [1:0] bias_sel = 2'd0;
  logic [CW-1:0] com_num = '0;
  logic [NCOM*NSEG-1:0] pix = '0;
  logic [NCOM-1:0] com_o;
  logic [NSEG-1:0] seg_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lcdpwm_drive #(.NCOM(NCOM), .NSEG(NSEG), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .sf_tick(sf_tick),
    .bias_sel(bias_sel), .com_num(com_num), .wave_b(wave_b), .pix(pix),
    .dead(dead), .com_o(com_o), .seg_o(seg_o));

  // Reference state, written from the requirements
  int m_ph, m_sf, m_half, m_den, m_m, m_wb;
  logic [NCOM-1:0] e_com;
  logic [NSEG-1:0] e_seg;
  logic e_dead;

  function automatic int clamp_m(int n);   // R8
    if (n < 2) return 2;
    if (n > NCOM) return NCOM;
    return n;
  endfunction

  function automatic int want_com(int i, int a, int pol, int b, int m);  // R4
    if (i >= m) return 0;
    if (i == a) return (pol == 0) ? b : 0;
    return (pol == 0) ? 1 : b - 1;
  endfunction

  function automatic int want_seg(bit on, int pol, int b);  // R5
    if (pol == 0) return on ? 0 : 2;
    return on ? b : b - 2;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin    // R9
      m_ph = 0; m_sf = 0; m_half = 0; m_den = 2; m_m = NCOM; m_wb = 0;
      e_com = '0; e_seg = '0; e_dead = 0;
    end else begin
      int pol, a, nsf;
      bit wrap;
      pol = m_wb ? ((m_sf >= m_m) ? 1 : 0) : m_half;
      a   = (m_wb && m_sf >= m_m) ? m_sf - m_m : m_sf;
      for (int i = 0; i < NCOM; i++)
        e_com[i] = dead | (m_ph < want_com(i, a, pol, m_den, m_m));   // R1 R10
      for (int j = 0; j < NSEG; j++)
        e_seg[j] = dead | (m_ph < want_seg(pix[j*NCOM + a], pol, m_den));
      e_dead = dead;
      nsf  = m_wb ? 2 * m_m : m_m;
      wrap = sf_tick && (m_sf == nsf - 1);
      if (wrap) begin     // R7
        m_sf = 0; m_ph = 0; m_half = 0;
        m_den = int'(bias_sel) + 2; m_m = clamp_m(int'(com_num)); m_wb = int'(wave_b);
      end else begin
        if (sf_tick) m_sf = m_sf + 1;
        if (step_en) begin
          if (m_ph == m_den - 1) begin
            m_ph = 0;
            if (m_wb == 0) m_half = 1 - m_half;
          end else m_ph = m_ph + 1;
        end
      end
    end
  end

  task automatic check_outputs();
    string tc, ts;
    tc = e_dead ? "R6" : (m_wb != 0 ? "R3 R4" : "R2 R4");
    ts = e_dead ? "R6" : "R5";
    checks++;
    if (com_o !== e_com) begin
      fails++;
      $display("FAIL %s (model also covers R1 R7 R8 R10): com_o=%b expected %b", tc, com_o, e_com);
    end
    checks++;
    if (seg_o !== e_seg) begin
      fails++;
      $display("FAIL %s (model also covers R1 R7 R8 R10): seg_o=%b expected %b", ts, seg_o, e_seg);
    end
  endtask

  task automatic run_cycles(int n, int tick_mod, int dead_mod);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check_outputs();
      step_en = ($urandom % 4) != 0;
      sf_tick = ($urandom % tick_mod) == 0;
      dead    = ($urandom % dead_mod) == 0;
      if (($urandom % 40) == 0) begin
        bias_sel = 2'($urandom);
        com_num  = CW'($urandom);
        wave_b   = 1'($urandom);
        pix      = {$urandom, $urandom};
      end
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R9: reset holds outputs low
    checks++;
    if (com_o !== '0 || seg_o !== '0) begin
      fails++;
      $display("FAIL R9: com_o=%b seg_o=%b expected all 0", com_o, seg_o);
    end
    rst_n = 1'b1;
    // Directed: half bias default, steady stepping, no ticks (R1 R5)
    step_en = 1'b1;
    pix = 64'hA5A5_0F0F_3C3C_FF00;
    repeat (12) begin @(negedge clk); check_outputs(); end
    // Directed: request fifth bias, clamped count 0, type B, then wrap frame (R7 R8 R3)
    bias_sel = 2'd3; com_num = '0; wave_b = 1'b1;
    for (int k = 0; k < NCOM; k++) begin
      sf_tick = 1'b1; @(negedge clk); check_outputs();
      sf_tick = 1'b0; repeat (7) begin @(negedge clk); check_outputs(); end
    end
    // Directed: oversize count, type A, quarter bias (R8 R2)
    com_num = CW'(15); wave_b = 1'b0; bias_sel = 2'd2;
    repeat (4) begin
      sf_tick = 1'b1; @(negedge clk); check_outputs();
      sf_tick = 1'b0; repeat (9) begin @(negedge clk); check_outputs(); end
    end
    // Random mix
    run_cycles(6000, 9, 20);
    run_cycles(6000, 3, 50);
    run_cycles(4000, 25, 8);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule